// File: doc/BRIEF.md
# Power-Down and Reset Sequencing Controller

This block decides the device-level operating state of a clock generator from two multipurpose input pins and three configuration bits. The first pin works either as an active-low power-down request or as an output enable, depending on a mode bit. The second pin is an active-high reset. That reset either brings every register back to its default values or performs a clean restart that keeps the programmed registers and only restarts the outputs.

Both pins pass through a two-flop synchronizer and a debounce filter before they take effect. When the device leaves power-down or reset, the outputs stay held low for a fixed lock-wait interval. After that interval a single common release goes high, so all outputs start together. When defaults must be restored, a one-cycle reload pulse comes right before the lock-wait interval. A keep-alive bit chooses whether programmed register contents survive power-down.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: A pin change takes effect only after the synchronized level has differed from the filtered level for DEB_CYCLES consecutive cycles. A shorter pulse on either pin has no effect on any output.
- R2: When `cfg_pd_mode`=1, the power pin is a power-down input and `out_en` stays 1. When `cfg_pd_mode`=0, `out_en` follows the filtered pin level (1 = enabled) and a low pin never causes power-down.
- R3: While power-down is active (power-down mode, filtered pin low), `pwr_off`=1, `hold_low`=1 and `release_all`=0.
- R4: On leaving power-down with `cfg_keep_alive`=0, `load_defaults` pulses for one cycle and the lock-wait interval follows.
- R5: On leaving power-down with `cfg_keep_alive`=1 and no pending reset, no reload pulse is issued and the lock-wait interval starts at once.
- R6: With `cfg_clean_start`=0, a high reset pin holds outputs low (`hold_low`=1, `pwr_off`=0). On its release, one reload pulse is issued and then the lock-wait interval runs.
- R7: With `cfg_clean_start`=1, releasing the reset pin starts the lock-wait interval directly, with no reload pulse.
- R8: The lock-wait interval lasts exactly LOCK_WAIT cycles with `hold_low`=1. After it, `release_all` rises and `hold_low` falls in the same cycle.
- R9: `load_defaults` is high for exactly one cycle and is always followed by the lock-wait interval.
- R10: Power-down takes priority over reset. A reset seen during power-down changes no output until wake. At wake, a reset still high holds the outputs until it is released. A full-reload reset that has already ended causes a reload pulse.
- R11: While the block reset `rst_n` is low, `load_defaults`=1 and `hold_low`=1. After `rst_n` rises, the lock-wait interval runs and then `release_all` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pdoe_pin | input | 1 | Raw power-down / output-enable pin |
| reset_pin | input | 1 | Raw active-high reset pin |
| cfg_pd_mode | input | 1 | 1: power pin is power-down; 0: it is output enable |
| cfg_clean_start | input | 1 | 1: reset keeps registers; 0: reset reloads defaults |
| cfg_keep_alive | input | 1 | 1: registers survive power-down |
| load_defaults | output | 1 | One-cycle register-file reload request |
| pwr_off | output | 1 | PLL and output driver shutdown |
| hold_low | output | 1 | Force all clock outputs low |
| release_all | output | 1 | Common enable for all outputs |
| out_en | output | 1 | Output-enable level for outputs sensitive to it |

## Verification
The sequencer is driven through wake from power-down with keep-alive off and with keep-alive on. This tells the reload path apart from the retain path. Reset is released in both full-reload and clean-start configuration; since a clean start looks like a plain hold on the outputs, the cycle at which release rises is what tells the two apart. Short glitches on the pins separate the filtered response from a raw one. Reset held, or pulsed and dropped, inside power-down checks the priority rule and the deferred reload. The output-enable mode shows that a low pin gates `out_en` without shutting anything off. Every output change is compared against the exact cycle predicted from the synchronizer, debounce and lock-wait depths.

// File: rtl/pwr_rst_pkg.sv
// Shared types for the power-down / reset sequencing controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwr_rst_pkg;

    // Sequencer states; outputs are decoded from these.
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,   // outputs released
        ST_OFF    = 3'd1,   // power-down active
        ST_RHOLD  = 3'd2,   // reset pin high, outputs held low
        ST_RELOAD = 3'd3,   // one-cycle default reload
        ST_LOCK   = 3'd4    // lock-wait, outputs held low
    } seq_state_e;

endpackage

// File: rtl/pwr_rst_pin_filter.sv
// Pin conditioner: SYNC_STAGES-flop synchronizer followed by a debounce
// filter. The filtered level changes only after the synchronized level
// has differed from it for DEB_CYCLES consecutive cycles.
// Assumes: SYNC_STAGES >= 2, DEB_CYCLES >= 1.
module pwr_rst_pin_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   DEB_CYCLES  = 16,
    parameter logic RST_LEVEL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_filt
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   sync_lvl;

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RST_LEVEL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end

    // Count cycles of disagreement and accept the new level when long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= RST_LEVEL;
        end else if (sync_lvl == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            cnt_q  <= '0;
            filt_q <= sync_lvl;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pin_filt = filt_q;
endmodule

// File: rtl/pwr_rst_lock_timer.sv
// Lock-wait timer: counts while run is high and flags the last cycle of
// a LOCK_WAIT-cycle window. Dropping run restarts the window.
// Assumes: LOCK_WAIT >= 2.
module pwr_rst_lock_timer #(
    parameter int LOCK_WAIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(LOCK_WAIT + 1);

    logic [TW-1:0] cnt_q;

    // Advance the window counter while the sequencer waits for lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                  cnt_q <= '0;
        else if (cnt_q != TW'(LOCK_WAIT - 1)) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == TW'(LOCK_WAIT - 1));
endmodule

// File: rtl/pwr_rst_seq_fsm.sv
// Sequencer: takes the filtered pin requests and the configuration
// bits and walks through off / reset-hold / reload / lock-wait / run.
// Power-down wins over reset; a reset seen during power-down is
// remembered and applied on wake.
// Assumes: pd_req and rst_req are already synchronized and filtered.
module pwr_rst_seq_fsm
    import pwr_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       rst_req,
    input  logic       clean_start,
    input  logic       keep_alive,
    input  logic       lock_done,
    output seq_state_e state
);
    seq_state_e st_q, st_d;
    logic       pend_q;

    // Choose the next state from requests, configuration and the timer.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RELOAD: st_d = ST_LOCK;
            ST_RUN, ST_LOCK: begin
                if (pd_req)                          st_d = ST_OFF;
                else if (rst_req)                    st_d = ST_RHOLD;
                else if (st_q == ST_LOCK && lock_done) st_d = ST_RUN;
            end
            ST_RHOLD: begin
                if (pd_req)       st_d = ST_OFF;
                else if (!rst_req) st_d = clean_start ? ST_LOCK : ST_RELOAD;
            end
            ST_OFF: begin
                if (!pd_req) begin
                    if (rst_req)
                        st_d = ST_RHOLD;
                    else if (!keep_alive || (pend_q && !clean_start))
                        st_d = ST_RELOAD;
                    else
                        st_d = ST_LOCK;
                end
            end
            default: st_d = ST_RELOAD;
        endcase
    end

    // Hold the state; block reset behaves like a full reload.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RELOAD;
        else        st_q <= st_d;
    end

    // Remember a reset that arrives while powered down.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (st_q == ST_OFF && rst_req) pend_q <= 1'b1;
        else if (st_q != ST_OFF)          pend_q <= 1'b0;
    end

    assign state = st_q;
endmodule

// File: rtl/pwr_rst_ctrl.sv
// Top of the power-down / reset sequencing controller. Conditions both
// pins, resolves the power pin mode, runs the sequencer and lock timer
// and decodes the output controls.
// Assumes: configuration bits change only while the pins are quiet.
module pwr_rst_ctrl
    import pwr_rst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 16,
    parameter int LOCK_WAIT   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdoe_pin,
    input  logic reset_pin,
    input  logic cfg_pd_mode,
    input  logic cfg_clean_start,
    input  logic cfg_keep_alive,
    output logic load_defaults,
    output logic pwr_off,
    output logic hold_low,
    output logic release_all,
    output logic out_en
);
    localparam int N_PINS = 2;
    localparam logic [N_PINS-1:0] PIN_IDLE = 2'b01; // [0]=power pin high, [1]=reset low

    logic [N_PINS-1:0] raw_pins, filt_pins;
    logic              pd_req, rst_req, lock_done;
    seq_state_e        state;

    assign raw_pins = {reset_pin, pdoe_pin};

    // One conditioner per pin, each with its own idle level.
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        pwr_rst_pin_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .DEB_CYCLES  (DEB_CYCLES),
            .RST_LEVEL   (PIN_IDLE[g])
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (raw_pins[g]),
            .pin_filt (filt_pins[g])
        );
    end

    assign pd_req  = cfg_pd_mode && !filt_pins[0];
    assign rst_req = filt_pins[1];

    pwr_rst_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req      (pd_req),
        .rst_req     (rst_req),
        .clean_start (cfg_clean_start),
        .keep_alive  (cfg_keep_alive),
        .lock_done   (lock_done),
        .state       (state)
    );

    pwr_rst_lock_timer #(.LOCK_WAIT(LOCK_WAIT)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_LOCK),
        .done  (lock_done)
    );

    // Decode output controls from the sequencer state.
    always_comb begin
        load_defaults = (state == ST_RELOAD);
        pwr_off       = (state == ST_OFF);
        hold_low      = (state != ST_RUN);
        release_all   = (state == ST_RUN);
        out_en        = cfg_pd_mode || filt_pins[0];
    end
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
// Property checker for the sequencing controller, bound to every
// instance of the top. Observes ports only.
// Assumes: LOCK_WAIT matches the bound instance.
module pwr_rst_ctrl_chk #(
    parameter int LOCK_WAIT = 64
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_pd_mode,
    input logic load_defaults,
    input logic pwr_off,
    input logic hold_low,
    input logic release_all
);
    localparam int HW = $clog2(LOCK_WAIT + 1);

    logic [HW-1:0] held_cnt;

    // Count consecutive held, powered, non-reload cycles (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_low || pwr_off || load_defaults) held_cnt <= '0;
        else if (held_cnt != HW'(LOCK_WAIT))                 held_cnt <= held_cnt + 1'b1;
    end

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults |=> !load_defaults); // R9
    AST_LOAD_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults |=> (hold_low && !pwr_off && !release_all)); // R9
    AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off |-> (hold_low && !release_all)); // R3
    AST_LOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(release_all) |-> (held_cnt >= HW'(LOCK_WAIT))); // R8
    AST_OFF_NEEDS_PD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off) |-> $past(cfg_pd_mode)); // R2
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(.LOCK_WAIT(LOCK_WAIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pd_mode   (cfg_pd_mode),
    .load_defaults (load_defaults),
    .pwr_off       (pwr_off),
    .hold_low      (hold_low),
    .release_all   (release_all)
);

// File: tb/pwr_rst_ctrl_test.sv
// Scoreboard bench: drivers queue each expected output vector with the
// exact cycle it must appear; a monitor compares every output change.
module pwr_rst_ctrl_test;
    localparam int DEB = 4;
    localparam int LW  = 8;
    localparam int T   = DEB + 3;   // raw pin change to state change
    localparam int TOE = DEB + 2;   // raw pin change to filtered level

    // vector = {load_defaults, pwr_off, hold_low, release_all, out_en}
    localparam logic [4:0] V_RUN  = 5'b00011;
    localparam logic [4:0] V_RUNX = 5'b00010;
    localparam logic [4:0] V_OFF  = 5'b01101;
    localparam logic [4:0] V_HOLD = 5'b00101;
    localparam logic [4:0] V_LOAD = 5'b10101;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pdoe_pin = 1'b1, reset_pin = 1'b0;
    logic cfg_pd_mode = 1'b1, cfg_clean_start = 1'b0, cfg_keep_alive = 1'b0;
    logic load_defaults, pwr_off, hold_low, release_all, out_en;

    pwr_rst_ctrl #(.SYNC_STAGES(2), .DEB_CYCLES(DEB), .LOCK_WAIT(LW)) uut (
        .clk(clk), .rst_n(rst_n), .pdoe_pin(pdoe_pin), .reset_pin(reset_pin),
        .cfg_pd_mode(cfg_pd_mode), .cfg_clean_start(cfg_clean_start),
        .cfg_keep_alive(cfg_keep_alive), .load_defaults(load_defaults),
        .pwr_off(pwr_off), .hold_low(hold_low), .release_all(release_all),
        .out_en(out_en)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [4:0] vec;
        int         at;
        string      req;
    } exp_t;

    exp_t       q[$];
    int         checks = 0, fails = 0, cyc = 0;
    logic [4:0] prev = '0;
    wire  [4:0] vec = {load_defaults, pwr_off, hold_low, release_all, out_en};

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every output change must match the head of the queue.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && vec !== prev) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected change actual=%b@%0d expected=none", vec, cyc);
            end else begin
                e = q.pop_front();
                if (vec !== e.vec || cyc != e.at) begin
                    fails++;
                    $display("FAIL %s actual=%b@%0d expected=%b@%0d", e.req, vec, cyc, e.vec, e.at);
                end
            end
        end
        prev = vec;
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic expect_at(logic [4:0] v, int at, string req);
        exp_t e;
        e.vec = v; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    // Let everything settle, then nothing may remain pending.
    task automatic idle(string req, logic [4:0] want);
        tick(40);
        checks++;
        if (q.size() != 0 || vec !== want) begin
            fails++;
            $display("FAIL %s idle pending=%0d actual=%b expected=%b", req, q.size(), vec, want);
            q.delete();
        end
    endtask

    initial begin
        int n;
        tick(3);
        // R11: state held while block reset is low
        checks++;
        if (vec !== V_LOAD) begin
            fails++;
            $display("FAIL R11 reset actual=%b expected=%b", vec, V_LOAD);
        end
        n = cyc; rst_n = 1'b1;
        expect_at(V_HOLD, n + 1, "R11");
        expect_at(V_RUN, n + 1 + LW, "R11");
        idle("R11", V_RUN);

        // R1: short glitches on either pin are filtered out
        pdoe_pin = 1'b0; tick(DEB / 2); pdoe_pin = 1'b1;
        tick(5);
        reset_pin = 1'b1; tick(DEB / 2); reset_pin = 1'b0;
        idle("R1", V_RUN);

        // R3/R4/R8/R9: power-down, wake with keep-alive off
        n = cyc; pdoe_pin = 1'b0;
        expect_at(V_OFF, n + T, "R3");
        idle("R3", V_OFF);
        n = cyc; pdoe_pin = 1'b1;
        expect_at(V_LOAD, n + T, "R4");
        expect_at(V_HOLD, n + T + 1, "R9");
        expect_at(V_RUN, n + T + 1 + LW, "R8");
        idle("R4", V_RUN);

        // R5: keep-alive on, no reload on wake
        cfg_keep_alive = 1'b1;
        n = cyc; pdoe_pin = 1'b0;
        expect_at(V_OFF, n + T, "R5");
        idle("R5", V_OFF);
        n = cyc; pdoe_pin = 1'b1;
        expect_at(V_HOLD, n + T, "R5");
        expect_at(V_RUN, n + T + LW, "R5");
        idle("R5", V_RUN);

        // R6: full-reload reset
        n = cyc; reset_pin = 1'b1;
        expect_at(V_HOLD, n + T, "R6");
        idle("R6", V_HOLD);
        n = cyc; reset_pin = 1'b0;
        expect_at(V_LOAD, n + T, "R6");
        expect_at(V_HOLD, n + T + 1, "R6");
        expect_at(V_RUN, n + T + 1 + LW, "R6");
        idle("R6", V_RUN);

        // R7: clean start, registers kept, no reload
        cfg_clean_start = 1'b1;
        n = cyc; reset_pin = 1'b1;
        expect_at(V_HOLD, n + T, "R7");
        idle("R7", V_HOLD);
        n = cyc; reset_pin = 1'b0;
        expect_at(V_RUN, n + T + LW, "R7");
        idle("R7", V_RUN);

        // R10: full reset pulsed inside power-down, applied at wake
        cfg_clean_start = 1'b0;
        n = cyc; pdoe_pin = 1'b0;
        expect_at(V_OFF, n + T, "R10");
        idle("R10", V_OFF);
        reset_pin = 1'b1; tick(20); reset_pin = 1'b0;
        idle("R10", V_OFF);
        n = cyc; pdoe_pin = 1'b1;
        expect_at(V_LOAD, n + T, "R10");
        expect_at(V_HOLD, n + T + 1, "R10");
        expect_at(V_RUN, n + T + 1 + LW, "R10");
        idle("R10", V_RUN);

        // R10: reset still high at wake holds outputs (clean start)
        cfg_clean_start = 1'b1;
        n = cyc; pdoe_pin = 1'b0;
        expect_at(V_OFF, n + T, "R10");
        idle("R10", V_OFF);
        reset_pin = 1'b1; tick(20);
        n = cyc; pdoe_pin = 1'b1;
        expect_at(V_HOLD, n + T, "R10");
        idle("R10", V_HOLD);
        n = cyc; reset_pin = 1'b0;
        expect_at(V_RUN, n + T + LW, "R10");
        idle("R10", V_RUN);

        // R2: output-enable mode gates out_en only
        cfg_pd_mode = 1'b0;
        idle("R2", V_RUN);
        n = cyc; pdoe_pin = 1'b0;
        expect_at(V_RUNX, n + TOE, "R2");
        idle("R2", V_RUNX);
        n = cyc; pdoe_pin = 1'b1;
        expect_at(V_RUN, n + TOE, "R2");
        idle("R2", V_RUN);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule